// File: doc/BRIEF.md
# Leveled Speculative Store Buffer

This block keeps the stores made on a wrong execution path away from main memory. A store issued while speculating lands in a small set-associative buffer instead. Each entry holds the store address, up to eight data bytes, and the speculation depth that was current when the entry was created. Loads issued while speculating look in the buffer first. On a miss they read a backing-memory port, and the buffer keeps no copy of what they read.

The speculation depth comes in on `curLevel`. A write that matches an entry stamped with the current depth updates that entry. Otherwise it creates a fresh entry at the current depth with its data zeroed, so each depth keeps its own copy of an address. When several entries match a load address, the entry with the deepest stamp supplies the data.

A recovery command names a depth. It releases every entry stamped at that depth or deeper in a single cycle and leaves shallower entries untouched. Read data arrives one cycle after the request, whether it comes from the buffer or from backing memory.

Top module: `spec_store_buf`

## Requirements
- R1: The set index is the XOR of address bytes [31:24], [23:16], [15:8] and [7:0], truncated to log2(SETS) bits.
- R2: A read that hits returns the low `reqSize` bytes of the deepest matching entry, right-justified with upper bytes zero, and raises no `memReq`.
- R3: A write that hits an entry stamped with the current level replaces only the low `reqSize` bytes of that entry and keeps the other bytes.
- R4: A write with no match at the current level allocates the lowest free way in its set, stamps it with `curLevel`, and stores the written bytes over zeroed data.
- R5: A legal read with no match raises `memReq` in the same cycle with `memAddr` equal to `reqAddr`. The next cycle it returns the low `reqSize` bytes of `memRdData` and allocates nothing.
- R6: When entries for one address exist at several levels, a read returns the data of the entry with the highest level.
- R7: Recovery to level L frees every entry whose level is greater than or equal to L, keeps all others, and makes freed ways available for new writes.
- R8: `reqSize` counts bytes. Only 1, 2, 4 and 8 are legal, and the address must be a multiple of the size. An illegal read returns zero without `memReq`, and an illegal write changes nothing.
- R9: A legal write that needs a new entry in a set whose ways are all valid asserts `stall` in that cycle and is not accepted. A write that hits at the current level never stalls.
- R10: `rdValid` is high exactly in the cycle after a read request is accepted.
- R11: A request in the same cycle as `recoverValid` is dropped: no `memReq`, no `stall`, no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the access |
| reqSize | input | 4 | Access size in bytes |
| reqData | input | 64 | Write data, right-justified |
| curLevel | input | LVL_W | Current speculation level |
| recoverValid | input | 1 | Recovery command |
| recoverLevel | input | LVL_W | Lowest level released by recovery |
| memReq | output | 1 | Backing-memory read request |
| memAddr | output | 32 | Backing-memory read address |
| memRdData | input | 64 | Backing-memory data, valid the cycle after `memReq` |
| rdValid | output | 1 | Read response valid |
| rdData | output | 64 | Read response data |
| stall | output | 1 | Write refused because its set is full |

## Verification
The checker assumes that backing memory answers every `memReq` on the very next cycle and that requests change only between clock edges. The bench honours this with a registered memory model driven from `memAddr`, and it drives every input on the falling edge. The checker's response-timing properties also assume that recovery and a request may coincide. The stimulus therefore issues such a pair once, deliberately, and otherwise keeps recovery on idle cycles. Addresses are chosen so that several of them fold onto one set through their upper bytes. This fills the set through the hash rather than through the low address bits.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int SIZE_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic doWrite;
    logic doAlloc;
    logic doRecover;
    logic respLoad;
    logic respFromMem;
    logic respZero;
  } ssbStrobe_t;

  function automatic logic [7:0] foldAddr(input logic [ADDR_W-1:0] a);
    return a[31:24] ^ a[23:16] ^ a[15:8] ^ a[7:0];
  endfunction

  function automatic logic [DATA_W-1:0] byteMask(input logic [SIZE_W-1:0] sz);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W / 8; i++) begin
      if (i < int'(sz)) m[i*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

  function automatic logic sizeLegal(input logic [SIZE_W-1:0] sz, input logic [2:0] lowA);
    case (sz)
      4'd1:    return 1'b1;
      4'd2:    return lowA[0] == 1'b0;
      4'd4:    return lowA[1:0] == 2'b00;
      4'd8:    return lowA == 3'b000;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [2:0]        reqAddrLow,
  input  logic              recoverValid,
  input  logic              hitAny,
  input  logic              hitCur,
  input  logic [WAYS-1:0]   curOh,
  input  logic [WAYS-1:0]   freeOh,
  input  logic              setFull,
  output ssbStrobe_t        strobe,
  output logic [WAYS-1:0]   wayOh,
  output logic              memReq,
  output logic              stall
);
  logic accept;
  logic legal;
  logic isRead;
  logic isWrite;

  assign accept  = reqValid && !recoverValid;
  assign legal   = sizeLegal(reqSize, reqAddrLow);
  assign isRead  = accept && !reqWrite;
  assign isWrite = accept && reqWrite && legal;

  always_comb begin
    strobe             = '0;
    wayOh              = '0;
    stall              = 1'b0;
    strobe.doRecover   = recoverValid;
    strobe.respLoad    = isRead;
    strobe.respZero    = isRead && !legal;
    strobe.respFromMem = isRead && legal && !hitAny;
    if (isWrite) begin
      if (hitCur) begin
        strobe.doWrite = 1'b1;
        wayOh          = curOh;
      end else if (!setFull) begin
        strobe.doWrite = 1'b1;
        strobe.doAlloc = 1'b1;
        wayOh          = freeOh;
      end else begin
        stall = 1'b1;
      end
    end
  end

  assign memReq = strobe.respFromMem;
endmodule

// File: rtl/ssb_datapath.sv
module ssb_datapath
  import ssb_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssbStrobe_t        strobe,
  input  logic [WAYS-1:0]   wayOh,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LVL_W-1:0]  curLevel,
  input  logic [LVL_W-1:0]  recoverLevel,
  input  logic [DATA_W-1:0] memRdData,
  output logic              hitAny,
  output logic              hitCur,
  output logic [WAYS-1:0]   curOh,
  output logic [WAYS-1:0]   freeOh,
  output logic              setFull,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int SET_W = $clog2(SETS);

  logic              entValid [SETS][WAYS];
  logic [ADDR_W-1:0] entAddr  [SETS][WAYS];
  logic [LVL_W-1:0]  entLvl   [SETS][WAYS];
  logic [DATA_W-1:0] entData  [SETS][WAYS];

  logic [SET_W-1:0]  setIdx;
  logic [WAYS-1:0]   hitVec;
  logic [WAYS-1:0]   freeVec;
  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] bestData;
  logic [LVL_W-1:0]  bestLvl;

  assign setIdx   = SET_W'(foldAddr(reqAddr));
  assign sizeMask = byteMask(reqSize);

  // per-way tag compare
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w]  = entValid[setIdx][w] && (entAddr[setIdx][w] == reqAddr);
    assign curOh[w]   = hitVec[w] && (entLvl[setIdx][w] == curLevel);
    assign freeVec[w] = !entValid[setIdx][w];
  end

  assign hitCur  = |curOh;
  assign setFull = ~|freeVec;

  // lowest free way
  always_comb begin
    freeOh = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (freeVec[w]) freeOh = WAYS'(1) << w;
    end
  end

  // deepest matching entry
  always_comb begin
    hitAny   = 1'b0;
    bestLvl  = '0;
    bestData = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w] && (!hitAny || entLvl[setIdx][w] > bestLvl)) begin
        hitAny   = 1'b1;
        bestLvl  = entLvl[setIdx][w];
        bestData = entData[setIdx][w];
      end
    end
  end

  // valid bits: recovery release, then write set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          entValid[s][w] <= 1'b0;
    end else begin
      if (strobe.doRecover) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (entValid[s][w] && entLvl[s][w] >= recoverLevel)
              entValid[s][w] <= 1'b0;
      end
      if (strobe.doWrite) begin
        for (int w = 0; w < WAYS; w++)
          if (wayOh[w]) entValid[setIdx][w] <= 1'b1;
      end
    end
  end

  // payload
  always_ff @(posedge clk) begin
    if (strobe.doWrite) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wayOh[w]) begin
          if (strobe.doAlloc) begin
            entAddr[setIdx][w] <= reqAddr;
            entLvl[setIdx][w]  <= curLevel;
            entData[setIdx][w] <= reqData & sizeMask;
          end else begin
            entData[setIdx][w] <= (entData[setIdx][w] & ~sizeMask) | (reqData & sizeMask);
          end
        end
      end
    end
  end

  // response stage
  logic              respValid;
  logic              respMem;
  logic [DATA_W-1:0] respHold;
  logic [DATA_W-1:0] respMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respMem   <= 1'b0;
      respHold  <= '0;
      respMask  <= '0;
    end else begin
      respValid <= strobe.respLoad;
      if (strobe.respLoad) begin
        respMem  <= strobe.respFromMem;
        respMask <= strobe.respZero ? '0 : sizeMask;
        respHold <= strobe.respZero ? '0 : (bestData & sizeMask);
      end
    end
  end

  assign rdValid = respValid;
  assign rdData  = respMem ? (memRdData & respMask) : respHold;
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
  import ssb_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [31:0]       reqAddr,
  input  logic [3:0]        reqSize,
  input  logic [63:0]       reqData,
  input  logic [LVL_W-1:0]  curLevel,
  input  logic              recoverValid,
  input  logic [LVL_W-1:0]  recoverLevel,
  output logic              memReq,
  output logic [31:0]       memAddr,
  input  logic [63:0]       memRdData,
  output logic              rdValid,
  output logic [63:0]       rdData,
  output logic              stall
);
  ssbStrobe_t      strobe;
  logic [WAYS-1:0] wayOh;
  logic [WAYS-1:0] curOh;
  logic [WAYS-1:0] freeOh;
  logic            hitAny;
  logic            hitCur;
  logic            setFull;

  ssb_ctrl #(.WAYS(WAYS)) u_ctrl (
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqSize      (reqSize),
    .reqAddrLow   (reqAddr[2:0]),
    .recoverValid (recoverValid),
    .hitAny       (hitAny),
    .hitCur       (hitCur),
    .curOh        (curOh),
    .freeOh       (freeOh),
    .setFull      (setFull),
    .strobe       (strobe),
    .wayOh        (wayOh),
    .memReq       (memReq),
    .stall        (stall)
  );

  ssb_datapath #(.SETS(SETS), .WAYS(WAYS), .LVL_W(LVL_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wayOh        (wayOh),
    .reqAddr      (reqAddr),
    .reqSize      (reqSize),
    .reqData      (reqData),
    .curLevel     (curLevel),
    .recoverLevel (recoverLevel),
    .memRdData    (memRdData),
    .hitAny       (hitAny),
    .hitCur       (hitCur),
    .curOh        (curOh),
    .freeOh       (freeOh),
    .setFull      (setFull),
    .rdValid      (rdValid),
    .rdData       (rdData)
  );

  assign memAddr = reqAddr;
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [31:0] reqAddr,
  input logic [3:0]  reqSize,
  input logic        recoverValid,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        rdValid,
  input logic [63:0] rdData,
  input logic        stall
);
  logic [3:0] sizeLess;
  logic       sizeOk;
  logic       readReq;

  assign sizeLess = reqSize - 4'd1;
  assign sizeOk   = ($countones(reqSize) == 1) && (reqSize <= 4'd8)
                    && ((reqAddr[3:0] & sizeLess) == 4'd0);
  assign readReq  = reqValid && !reqWrite && !recoverValid;

  AST_STALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (reqValid && reqWrite && !recoverValid)); // R9

  AST_MEMREQ_LEGAL_READ: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (readReq && sizeOk)); // R5

  AST_MEMADDR_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr == reqAddr)); // R5

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    readReq |=> rdValid); // R10

  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |=> !rdValid); // R10

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && !sizeOk) |=> (rdData == 64'd0)); // R8

  AST_RECOVER_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    recoverValid |-> (!memReq && !stall)); // R11
endmodule

bind spec_store_buf ssb_checker u_ssb_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqWrite     (reqWrite),
  .reqAddr      (reqAddr),
  .reqSize      (reqSize),
  .recoverValid (recoverValid),
  .memReq       (memReq),
  .memAddr      (memAddr),
  .rdValid      (rdValid),
  .rdData       (rdData),
  .stall        (stall)
);

// File: tb/test_spec_store_buf.sv
`timescale 1ns/1ps
module test_spec_store_buf;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqSize = '0;
  logic [63:0] reqData = '0;
  logic [2:0]  curLevel = '0;
  logic        recoverValid = 1'b0;
  logic [2:0]  recoverLevel = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [63:0] memRdData = '0;
  logic        rdValid;
  logic [63:0] rdData;
  logic        stall;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  spec_store_buf i_spec_store_buf (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqData(reqData),
    .curLevel(curLevel), .recoverValid(recoverValid), .recoverLevel(recoverLevel),
    .memReq(memReq), .memAddr(memAddr), .memRdData(memRdData),
    .rdValid(rdValid), .rdData(rdData), .stall(stall)
  );

  function automatic logic [63:0] memVal(input logic [31:0] a);
    return {a ^ 32'hA5A5A5A5, ~a};
  endfunction

  function automatic logic [63:0] szMask(input int n);
    logic [63:0] m = '0;
    for (int i = 0; i < n; i++) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  // backing memory: data one cycle after the request
  always @(posedge clk) if (memReq) memRdData <= memVal(memAddr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compares every response against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && rdValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R10", "unexpected response", rdData, 64'd0);
        end else begin
          logic [63:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(rdData === e, t, "read data", rdData, e);
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input int sz,
                        input logic [63:0] d, input logic [2:0] lvl,
                        input bit expStall, input bit expMem,
                        input logic [63:0] expRd, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = 4'(sz);
    reqData = d; curLevel = lvl;
    #1;
    chk(stall === expStall, req, "stall", 64'(stall), 64'(expStall));
    chk(memReq === expMem, req, "memReq", 64'(memReq), 64'(expMem));
    if (expMem) chk(memAddr === a, req, "memAddr", 64'(memAddr), 64'(a));
    if (!wr) begin
      expQ.push_back(expRd);
      tagQ.push_back(req);
    end
    @(posedge clk);
    #2;
    reqValid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input int sz, input logic [63:0] d,
                    input logic [2:0] lvl, input bit expStall, input string req);
    access(1'b1, a, sz, d, lvl, expStall, 1'b0, 64'd0, req);
  endtask

  task automatic rdHit(input logic [31:0] a, input int sz, input logic [63:0] e, input string req);
    access(1'b0, a, sz, 64'd0, curLevel, 1'b0, 1'b0, e, req);
  endtask

  task automatic rdMiss(input logic [31:0] a, input int sz, input string req);
    access(1'b0, a, sz, 64'd0, curLevel, 1'b0, 1'b1, memVal(a) & szMask(sz), req);
  endtask

  task automatic recover(input logic [2:0] l);
    @(negedge clk);
    recoverValid = 1'b1; recoverLevel = l;
    @(posedge clk);
    #2;
    recoverValid = 1'b0;
  endtask

  // addresses folding onto set 4 (fold low bits = 4)
  localparam logic [31:0] A0 = 32'h0000_0004;
  localparam logic [31:0] A1 = 32'h0000_0C00;
  localparam logic [31:0] A2 = 32'h0400_0000;
  localparam logic [31:0] A3 = 32'h0014_0000;
  localparam logic [31:0] A4 = 32'h0000_0014;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rdValid === 1'b0, "R10", "reset rdValid", 64'(rdValid), 64'd0);
    chk(stall === 1'b0, "R9", "reset stall", 64'(stall), 64'd0);
    chk(memReq === 1'b0, "R5", "reset memReq", 64'(memReq), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    curLevel = 3'd1;

    // R2 hit reads at several sizes
    wr(32'h100, 8, 64'h1122334455667788, 3'd1, 1'b0, "R4");
    rdHit(32'h100, 4, 64'h55667788, "R2");
    rdHit(32'h100, 8, 64'h1122334455667788, "R2");
    rdHit(32'h100, 1, 64'h88, "R2");
    // R3 partial update
    wr(32'h100, 1, 64'hFFFF_FFFF_FFFF_FFAA, 3'd1, 1'b0, "R3");
    rdHit(32'h100, 8, 64'h11223344556677AA, "R3");
    // R4 new entry with cleared data
    wr(32'h200, 2, 64'hDEAD_BEEF_CAFE_BEEF, 3'd1, 1'b0, "R4");
    rdHit(32'h200, 8, 64'h000000000000BEEF, "R4");
    // R5 miss, no allocation
    rdMiss(32'h300, 4, "R5");
    rdMiss(32'h300, 4, "R5");
    rdMiss(32'h308, 8, "R5");
    // R8 illegal accesses
    rdHit(32'h100, 3, 64'd0, "R8");
    rdHit(32'h102, 4, 64'd0, "R8");
    wr(32'h402, 4, 64'h12345678, 3'd1, 1'b0, "R8");
    rdMiss(32'h402, 2, "R8");
    // R6 deepest level wins
    wr(32'h500, 4, 64'h11111111, 3'd1, 1'b0, "R6");
    wr(32'h500, 4, 64'h33333333, 3'd3, 1'b0, "R6");
    rdHit(32'h500, 4, 64'h33333333, "R6");
    wr(32'h500, 2, 64'h2222, 3'd2, 1'b0, "R6");
    rdHit(32'h500, 4, 64'h33333333, "R6");
    recover(3'd3);
    rdHit(32'h500, 4, 64'h00002222, "R7");
    recover(3'd2);
    rdHit(32'h500, 4, 64'h11111111, "R7");
    // R1 / R9 set hashing and full-set stall
    curLevel = 3'd2;
    wr(A0, 4, 64'hA0A0A0A0, 3'd2, 1'b0, "R1");
    wr(A1, 4, 64'hA1A1A1A1, 3'd2, 1'b0, "R1");
    wr(A2, 4, 64'hA2A2A2A2, 3'd2, 1'b0, "R1");
    wr(A3, 4, 64'hA3A3A3A3, 3'd2, 1'b0, "R1");
    wr(A4, 4, 64'hA4A4A4A4, 3'd2, 1'b1, "R9");
    wr(32'h8, 4, 64'h08080808, 3'd2, 1'b0, "R1");
    wr(A0, 4, 64'h0B0B0B0B, 3'd2, 1'b0, "R9");
    rdHit(A0, 4, 64'h0B0B0B0B, "R9");
    rdHit(A2, 4, 64'hA2A2A2A2, "R1");
    rdMiss(A4, 4, "R9");
    // R7 release by level and reuse
    recover(3'd2);
    rdMiss(A0, 4, "R7");
    rdMiss(32'h8, 4, "R7");
    rdHit(32'h100, 8, 64'h11223344556677AA, "R7");
    rdHit(32'h500, 4, 64'h11111111, "R7");
    wr(A4, 4, 64'hA4A4A4A4, 3'd2, 1'b0, "R7");
    rdHit(A4, 4, 64'hA4A4A4A4, "R7");
    // R11 request dropped during recovery
    @(negedge clk);
    recoverValid = 1'b1; recoverLevel = 3'd5;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 32'h300; reqSize = 4'd4;
    #1;
    chk(memReq === 1'b0, "R11", "memReq during recovery", 64'(memReq), 64'd0);
    @(posedge clk);
    #2;
    chk(rdValid === 1'b0, "R11", "response during recovery", 64'(rdValid), 64'd0);
    recoverValid = 1'b0; reqValid = 1'b0;
    // R10 no response after a write
    wr(32'h600, 4, 64'h6, 3'd2, 1'b0, "R10");
    chk(rdValid === 1'b0, "R10", "rdValid after write", 64'(rdValid), 64'd0);

    repeat (4) @(posedge clk);
    #3;
    chk(expQ.size() == 0, "R10", "missing responses", 64'(expQ.size()), 64'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule